// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a word-wide, register-programmed SPI master. Software writes one
data word into a small transmit queue, picks a frame length between 1 and 32
bits, and sets a start bit. The engine then clocks the word out most significant
bit first on `sclk`/`mosi`, gathers the same number of bits from `miso`, and
places the gathered word, right-aligned, in a receive queue. Software can then
read that word from a fixed port.

Error and completion conditions are held in sticky flags. Writing a one to a
flag bit clears it, so writing back a value just read from the flag register
clears every event it showed. The four select lines are driven either from a
software value bit or automatically around each frame, with an option to keep
the line asserted after the frame ends. The serial clock is the system clock
divided by a build-time half-period count. The clock idles low, and a mode bit
chooses the edge on which input is sampled.

Register map (byte offsets). Unlisted offsets read zero and ignore writes:
`0x000` control, `0x004` control-2, `0x008` flags, `0x01C` queue levels,
`0x100` transmit port (write only), `0x180` receive port (read pops).

Top module: `spi_regmaster`

## Requirements
- R1: After reset the flags register reads 0x00A00000 (both queues empty, nothing else set), the levels register and the control register read 0, all select lines are high and `sclk` is low.
- R2: Writing control bits 4:0 = n-1 together with start bit 30 sends bits n-1 down to 0 of the queued word on `mosi`, MSB first, with exactly n `sclk` pulses. Word bits above n-1 are not sent, and `sclk` is low whenever no frame is running.
- R3: The n bits gathered from `miso` enter the receive queue right-aligned, with zeros above bit n-1, and are read back in order at offset 0x180.
- R4: Flag bit 31 (busy) is 1 while a frame shifts. When the frame ends, flag bit 30 (done) becomes 1 and stays set, and control bit 30 reads 0 again.
- R5: A write to the flags register clears each sticky bit (30, 29, 25, 24, 19, 18) where the written data holds a 1, and leaves the bits written with 0 unchanged.
- R6: A write to 0x100 while the transmit queue holds FIFO_DEPTH words is dropped. It sets flag bit 19 (transmit overflow) and bit 29 (error). Flag bit 20 reads 1 while the transmit queue is full.
- R7: A read of 0x180 while the receive queue is empty returns 0 and sets flag bit 18 (receive underrun) and bit 29.
- R8: A start request while transmission is enabled and the transmit queue is empty produces no `sclk` pulse. It sets flag bits 24 and 29, leaves bit 30 clear, and control bit 30 reads 0.
- R9: A frame that ends while the receive queue is full and reception is enabled drops its word and sets flag bits 25 and 29. The words already in the queue are kept.
- R10: With control bit 11 (software select) set, control bit 12 asserts the line chosen by control-2 bits 19:18. An asserted line is low when control bit 13 is 0 and high when it is 1. Every other line sits at the inactive level.
- R11: With control bit 11 clear, the chosen line is asserted while busy. If control-2 bit 17 is set, the line stays asserted after the frame until bit 17 is written 0.
- R12: With control bit 21 = 0, `miso` is sampled on rising `sclk` edges and `mosi` changes only on falling edges. With bit 21 = 1, `mosi` changes on rising edges and `miso` is sampled on falling edges.
- R13: The levels register shows the receive queue count from bit 16 and the transmit queue count from bit 0. Writing 1 to flag bit 27 empties the receive queue, and writing 1 to flag bit 26 empties the transmit queue.
- R14: With control-2 bit 30 (transmit enable) clear, a frame sends zeros and leaves the transmit queue untouched. With control-2 bit 31 (receive enable) clear, the received word is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 9 | Byte offset of the accessed register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe; pops the receive queue at 0x180 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_o | output | 4 | Select lines, polarity set by control bit 13 |

## Verification
The assertions assume that a bus cycle asserts either the write strobe or the read strobe and never both. They also assume that `miso` changes only half an `sclk` period away from the sampling edge. The bench issues one bus access per cycle, driven on the falling system clock. Its slave model updates `miso` only on the `sclk` edge opposite to the sampling edge set by the mode bit. It captures `mosi` on the sampling edge, when the design leaves that line still.

// File: rtl/spi_regmaster.sv
module spi_regmaster #(
  parameter int HALF_DIV   = 2,
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [8:0]  bus_addr,
  input  logic        bus_we,
  input  logic        bus_re,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  ss_o
);
  localparam int PW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(FIFO_DEPTH);
  localparam logic [DW-1:0] DIV_END  = DW'(HALF_DIV - 1);
  localparam logic [PW-1:0] PTR_END  = PW'(FIFO_DEPTH - 1);
  localparam logic [8:0] A_CTL  = 9'h000;
  localparam logic [8:0] A_CTL2 = 9'h004;
  localparam logic [8:0] A_FLG  = 9'h008;
  localparam logic [8:0] A_LVL  = 9'h01C;
  localparam logic [8:0] A_TXP  = 9'h100;
  localparam logic [8:0] A_RXP  = 9'h180;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PTR_END) ? '0 : p + 1'b1;
  endfunction

  logic en_q, go_q, mst_q, edge_q, cspol_q, csval_q, cssoft_q;
  logic [4:0] len_q;
  logic rxen_q, txen_q, hold_q;
  logic [1:0] csidx_q;
  logic rdy_q, err_q, rxovf_q, txunr_q, txovf_q, rxunr_q;

  logic [31:0] tx_mem [FIFO_DEPTH];
  logic [31:0] rx_mem [FIFO_DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  logic busy_q, sclk_q, edge_f, hold_lat;
  logic [DW-1:0] div_q;
  logic [5:0] half_q, nlast_q;
  logic [31:0] shr_q, rxs_q;

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  wire wr_ctl  = bus_we && bus_addr == A_CTL;
  wire wr_ctl2 = bus_we && bus_addr == A_CTL2;
  wire wr_flg  = bus_we && bus_addr == A_FLG;
  wire wr_tx   = bus_we && bus_addr == A_TXP;
  wire rd_rx   = bus_re && bus_addr == A_RXP;

  wire tx_full  = tx_cnt == FULL_CNT;
  wire rx_full  = rx_cnt == FULL_CNT;
  wire tx_empty = tx_cnt == '0;
  wire rx_empty = rx_cnt == '0;

  wire tx_push  = wr_tx && !tx_full;
  wire rx_pop   = rd_rx && !rx_empty;
  wire tx_flush = wr_flg && bus_wdata[26];
  wire rx_flush = wr_flg && bus_wdata[27];

  wire start_try = go_q && !busy_q;
  wire no_data   = txen_q && tx_empty;
  wire start     = start_try && !no_data;
  wire go_fail   = start_try && no_data;
  wire tx_pop    = start && txen_q;

  wire tick   = busy_q && div_q == DIV_END;
  wire rise   = tick && !sclk_q;
  wire fall   = tick && sclk_q;
  wire last   = tick && half_q == nlast_q;
  wire sample = edge_f ? fall : rise;
  wire shift  = edge_f ? (rise && half_q != 6'd0) : (fall && !last);

  wire [31:0] rx_word = edge_f ? {rxs_q[30:0], miso} : rxs_q;
  wire rx_try  = last && rxen_q;
  wire rx_push = rx_try && !rx_full;

  wire ev_txovf = wr_tx && tx_full;
  wire ev_rxunr = rd_rx && rx_empty;
  wire ev_rxovf = rx_try && rx_full;
  wire ev_txunr = go_fail;
  wire [31:0] clr = wr_flg ? bus_wdata : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; go_q <= 1'b0; mst_q <= 1'b0; edge_q <= 1'b0;
      cspol_q <= 1'b0; csval_q <= 1'b0; cssoft_q <= 1'b0; len_q <= '0;
    end else begin
      if (wr_ctl) begin
        en_q     <= bus_wdata[31];
        go_q     <= bus_wdata[30];
        mst_q    <= bus_wdata[28];
        edge_q   <= bus_wdata[21];
        cspol_q  <= bus_wdata[13];
        csval_q  <= bus_wdata[12];
        cssoft_q <= bus_wdata[11];
        len_q    <= bus_wdata[4:0];
      end else if (last || go_fail) begin
        go_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxen_q <= 1'b0; txen_q <= 1'b0; csidx_q <= '0; hold_q <= 1'b0;
    end else if (wr_ctl2) begin
      rxen_q  <= bus_wdata[31];
      txen_q  <= bus_wdata[30];
      csidx_q <= bus_wdata[19:18];
      hold_q  <= bus_wdata[17];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0; err_q <= 1'b0; rxovf_q <= 1'b0;
      txunr_q <= 1'b0; txovf_q <= 1'b0; rxunr_q <= 1'b0;
    end else begin
      rdy_q   <= (rdy_q   & ~clr[30]) | last;
      err_q   <= (err_q   & ~clr[29]) | ev_txovf | ev_rxunr | ev_rxovf | ev_txunr;
      rxovf_q <= (rxovf_q & ~clr[25]) | ev_rxovf;
      txunr_q <= (txunr_q & ~clr[24]) | ev_txunr;
      txovf_q <= (txovf_q & ~clr[19]) | ev_txovf;
      rxunr_q <= (rxunr_q & ~clr[18]) | ev_rxunr;
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata;
    if (rx_push) rx_mem[rx_wp] <= rx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_flush) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= bump(tx_wp);
      if (tx_pop)  tx_rp <= bump(tx_rp);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_flush) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= bump(rx_wp);
      if (rx_pop)  rx_rp <= bump(rx_rp);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; sclk_q <= 1'b0; edge_f <= 1'b0;
      div_q <= '0; half_q <= '0; nlast_q <= '0;
      shr_q <= '0; rxs_q <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      sclk_q  <= 1'b0;
      div_q   <= '0;
      half_q  <= '0;
      nlast_q <= {len_q, 1'b1};
      edge_f  <= edge_q;
      rxs_q   <= '0;
      shr_q   <= (txen_q ? tx_mem[tx_rp] : 32'd0) << (5'd31 - len_q);
    end else if (busy_q) begin
      if (tick) begin
        div_q  <= '0;
        half_q <= half_q + 6'd1;
        sclk_q <= ~sclk_q;
        if (last) busy_q <= 1'b0;
      end else begin
        div_q <= div_q + 1'b1;
      end
      if (sample) rxs_q <= {rxs_q[30:0], miso};
      if (shift)  shr_q <= {shr_q[30:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_lat <= 1'b0;
    else if (!hold_q) hold_lat <= 1'b0;
    else if (last)    hold_lat <= 1'b1;
  end

  assign sclk = sclk_q;
  assign mosi = shr_q[31];

  wire cs_act = cssoft_q ? csval_q : (busy_q | hold_lat);
  for (genvar i = 0; i < 4; i++) begin : g_sel
    assign ss_o[i] = (cs_act && csidx_q == 2'(i)) ? cspol_q : ~cspol_q;
  end

  always_comb begin
    case (bus_addr)
      A_CTL:  bus_rdata = {en_q, go_q, 1'b0, mst_q, 6'd0, edge_q, 7'd0,
                           cspol_q, csval_q, cssoft_q, 6'd0, len_q};
      A_CTL2: bus_rdata = {rxen_q, txen_q, 10'd0, csidx_q, hold_q, 17'd0};
      A_FLG:  bus_rdata = {busy_q, rdy_q, err_q, 3'd0, rxovf_q, txunr_q,
                           rx_empty, rx_full, tx_empty, tx_full,
                           txovf_q, rxunr_q, 18'd0};
      A_LVL:  bus_rdata = (32'(rx_cnt) << 16) | 32'(tx_cnt);
      A_RXP:  bus_rdata = rx_empty ? 32'd0 : rx_mem[rx_rp];
      default: bus_rdata = 32'd0;
    endcase
  end

  p_idle_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sclk_q);
  p_done_after_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> rdy_q);
  p_go_selfclear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && !$past(wr_ctl)) |-> !go_q);
  p_tx_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && tx_full) |=> (txovf_q && err_q));
  p_rx_underrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && rx_empty) |=> (rxunr_q && err_q));
  p_no_frame_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (go_fail && !wr_ctl) |=> (!busy_q && !go_q && txunr_q));
  p_one_select_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ss_o ^ {4{~cspol_q}}) <= 1);
  p_mosi_steady_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !edge_f && rise) |=> $stable(mosi));
  p_level_bound_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= FULL_CNT) && (rx_cnt <= FULL_CNT));
  p_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));
endmodule

// File: tb/spi_regmaster_test.sv
`timescale 1ns/1ps
module spi_regmaster_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [8:0] bus_addr = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sclk, mosi, miso = 1'b0;
  logic [3:0] ss_o;

  spi_regmaster uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk),
    .mosi(mosi), .miso(miso), .ss_o(ss_o));

  always #2.5 clk = ~clk;

  localparam logic [8:0] CTL = 9'h000, CTL2 = 9'h004, FLG = 9'h008,
                         LVL = 9'h01C, TXP = 9'h100, RXP = 9'h180;
  localparam logic [31:0] GO = 32'h4000_0000, SOFT = 32'h0000_0800,
                          CSV = 32'h0000_1000, POL = 32'h0000_2000,
                          RXEN = 32'h8000_0000, TXEN = 32'h4000_0000,
                          HOLD = 32'h0002_0000;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] mosi_q[$];
  int len_q[$];
  logic [31:0] rx_q[$];
  logic [31:0] cap = '0, slave_w = '0;
  int capn = 0, sidx = 0, rises = 0;
  bit edge_mode = 0, saw_busy = 0;
  logic [3:0] ss_busy = 4'hF;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  task automatic capture();
    cap = {cap[30:0], mosi};
    capn++;
    if (len_q.size() > 0 && capn == len_q[0]) begin
      check("R2 mosi frame", cap & mask(len_q[0]), mosi_q.pop_front());
      void'(len_q.pop_front());
      capn = 0; cap = '0;
    end
  endtask

  task automatic drive_miso();
    if (sidx >= 0) begin miso = slave_w[sidx]; sidx--; end
  endtask

  always @(posedge sclk) begin
    rises++;
    if (!edge_mode) capture(); else drive_miso();
  end
  always @(negedge sclk) begin
    if (edge_mode) capture(); else drive_miso();
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1'b1;
    #2; d = bus_rdata;
    @(negedge clk); bus_re = 1'b0;
  endtask

  task automatic frame(input int len, input logic [31:0] txw, input logic [31:0] sw,
                       input bit mode, input logic [31:0] extra, input bit push_tx,
                       input bit keep_rx, input logic [31:0] mosi_exp);
    logic [31:0] s;
    int polls;
    edge_mode = mode; slave_w = sw; capn = 0; cap = '0;
    sidx = len - 1;
    if (!mode) begin miso = sw[len-1]; sidx = len - 2; end
    len_q.push_back(len);
    mosi_q.push_back(mosi_exp & mask(len));
    if (keep_rx) rx_q.push_back(sw & mask(len));
    if (push_tx) wr(TXP, txw);
    wr(FLG, 32'h4000_0000);
    saw_busy = 0;
    wr(CTL, extra | GO | (32'(mode) << 21) | 32'(len - 1));
    polls = 0;
    s = '0;
    while (!s[30] && polls < 1000) begin
      rd(FLG, s);
      if (s[31]) begin saw_busy = 1; ss_busy = ss_o; end
      polls++;
    end
    check("R4 frame done", 32'(s[30]), 32'd1);
  endtask

  task automatic rx_check(input string tag);
    logic [31:0] d;
    rd(RXP, d);
    check(tag, d, rx_q.size() > 0 ? rx_q.pop_front() : 32'hDEAD_0000);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [31:0] d;
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(FLG, d); check("R1 flags", d, 32'h00A0_0000);
    rd(LVL, d); check("R1 levels", d, 32'd0);
    rd(CTL, d); check("R1 control", d, 32'd0);
    check("R1 selects", 32'(ss_o), 32'hF);
    check("R1 sclk", 32'(sclk), 32'd0);

    wr(CTL2, RXEN | TXEN);
    // R2 R3 R4 byte frame, sample on rising edge
    frame(8, 32'hA5, 32'h3C, 0, SOFT | CSV, 1, 1, 32'hA5);
    check("R4 busy seen", 32'(saw_busy), 32'd1);
    rd(CTL, d); check("R4 go self-clear", 32'(d[30]), 32'd0);
    rd(FLG, d); check("R4 done sticky", 32'(d[30]), 32'd1);
    rx_check("R3 rx byte");
    check("R2 sclk idle", 32'(sclk), 32'd0);

    // R12 sample on falling edge, full word
    frame(32, 32'hDEAD_BEEF, 32'h1234_5678, 1, SOFT | CSV, 1, 1, 32'hDEAD_BEEF);
    rx_check("R12 rx word falling-edge mode");

    // R2 R3 odd length, upper bits ignored
    r0 = rises;
    frame(13, 32'hFFFF_E123, 32'h0000_1ABC, 0, SOFT | CSV, 1, 1, 32'h0000_0123);
    check("R2 pulse count", 32'(rises - r0), 32'd13);
    rx_check("R3 rx right-aligned");

    // R5 write-one-to-clear
    wr(FLG, 32'h0); rd(FLG, d); check("R5 zero write keeps", 32'(d[30]), 32'd1);
    wr(FLG, 32'h4000_0000); rd(FLG, d); check("R5 one write clears", 32'(d[30]), 32'd0);

    // R6 R13 transmit overflow, levels, flush
    for (int i = 0; i < 5; i++) wr(TXP, 32'(i));
    rd(LVL, d); check("R13 tx level", d, 32'd4);
    rd(FLG, d); check("R6 full/ovf/err", d & 32'h2018_0000, 32'h2018_0000);
    wr(FLG, 32'h0400_0000);
    rd(LVL, d); check("R13 tx flush", d, 32'd0);

    // R7 receive underrun
    wr(FLG, 32'hF3FF_FFFF);
    rd(RXP, d); check("R7 empty read data", d, 32'd0);
    rd(FLG, d); check("R7 underrun flag", d & 32'h2004_0000, 32'h2004_0000);

    // R8 start with empty transmit queue
    wr(FLG, 32'hFFFF_FFFF);
    r0 = rises;
    wr(CTL, GO | 32'd7);
    repeat (10) @(negedge clk);
    rd(FLG, d); check("R8 flags", d & 32'h6100_0000, 32'h2100_0000);
    rd(CTL, d); check("R8 go cleared", 32'(d[30]), 32'd0);
    check("R8 no pulses", 32'(rises - r0), 32'd0);

    // R9 receive overflow
    wr(FLG, 32'hFFFF_FFFF);
    for (int i = 0; i < 5; i++)
      frame(8, 32'(8'h10 + i), 32'(8'h80 + i), 0, SOFT | CSV, 1, (i < 4), 32'(8'h10 + i));
    rd(FLG, d); check("R9 overflow flag", d & 32'h2200_0000, 32'h2200_0000);
    rd(LVL, d); check("R9 rx level", d, 32'h0004_0000);
    for (int i = 0; i < 4; i++) rx_check("R9 kept words");

    // R10 software select
    wr(CTL2, RXEN | TXEN | (32'd2 << 18));
    wr(CTL, SOFT | CSV); @(negedge clk);
    check("R10 active low", 32'(ss_o), 32'hB);
    wr(CTL, SOFT | CSV | POL); @(negedge clk);
    check("R10 active high", 32'(ss_o), 32'h4);
    wr(CTL, SOFT); @(negedge clk);
    check("R10 released", 32'(ss_o), 32'hF);

    // R11 automatic select and hold
    wr(CTL2, RXEN | TXEN | (32'd1 << 18));
    frame(16, 32'h0000_C0DE, 32'h0000_BEAD, 1, 32'd0, 1, 1, 32'h0000_C0DE);
    check("R11 select during frame", 32'(ss_busy), 32'hD);
    check("R11 released after", 32'(ss_o), 32'hF);
    rx_check("R11 rx");
    wr(CTL2, RXEN | TXEN | (32'd1 << 18) | HOLD);
    frame(8, 32'h5A, 32'hC3, 0, 32'd0, 1, 1, 32'h5A);
    check("R11 held after frame", 32'(ss_o), 32'hD);
    wr(CTL2, RXEN | TXEN | (32'd1 << 18)); @(negedge clk);
    check("R11 hold cleared", 32'(ss_o), 32'hF);
    rx_check("R11 rx held");

    // R14 transmit disabled, then receive disabled
    wr(TXP, 32'hAB);
    wr(CTL2, RXEN);
    frame(8, 32'h0, 32'h5A, 0, SOFT | CSV, 0, 1, 32'h0);
    rd(LVL, d); check("R14 tx untouched", d, 32'h0001_0001);
    rx_check("R14 rx with tx off");
    wr(CTL2, TXEN);
    frame(8, 32'h0, 32'h77, 0, SOFT | CSV, 0, 0, 32'hAB);
    rd(LVL, d); check("R14 rx discarded", d, 32'd0);

    repeat (5) @(negedge clk);
    summary();
  end
endmodule